// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block feeds a MAC transmitter from memory without processor help. Software builds a list of fixed-size descriptors in memory and places the address of the first one on `list_base`. It then raises `tx_enable`. The engine reads each descriptor in turn. From it, it takes the buffer length and the buffer address. It fetches that buffer one 32-bit word at a time and hands the bytes to the MAC as a byte stream with start and end markers. It then writes a status word back into the descriptor and moves on to the next one.

Each descriptor takes 16 bytes: a control/status word at offset 0, a length word at offset 4, a buffer pointer at offset 8, and 4 bytes of padding. In the control word:

- bit 31 is the ownership flag.
- bit 30 makes the list wrap back to its start.
- bit 29 marks the first buffer of a frame.
- bit 28 marks the last buffer of a frame.
- bit 27 is a spare control flag.
- bits 26..0 are the status field that the engine writes back.

A frame may be carried in one buffer, or spread over several consecutive descriptors. The engine stops at the first descriptor that it does not own.

Memory is reached through a simple port with one transaction outstanding. The engine holds `mem_req` and its qualifiers until `mem_ack` arrives. Read data is taken in the `mem_ack` cycle.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `tx_active`, `tx_valid` and `mem_req` are all low.
- R2: When `tx_enable` rises while the engine is idle, it reads its first descriptor at `list_base`. It then walks the list in ascending address order, 16 bytes per descriptor.
- R3: A descriptor whose word 0 bit 31 is 0 is neither transmitted nor written. The engine drops `tx_active` and stays halted, with `tx_valid` low, until `tx_enable` goes low.
- R4: The buffer length is word 1 bits 31..16, and the buffer address is word 2. Exactly that many bytes are streamed in little-endian order: byte k of a word is bits 8k+7..8k. Every memory access uses a word-aligned address.
- R5: `tx_sop` is high on the first byte of a buffer whose descriptor has bit 29 set, and on no other byte. `tx_eop` is high on the final byte of a buffer whose descriptor has bit 28 set, and on no other byte.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values into the next cycle.
- R7: The write-back to word 0 has bit 31 cleared and bits 30..27 as read. Status bit 0 is the error flag, and status bits 26..1 are zero.
- R8: A length of zero, or a buffer address with bits 1..0 not zero, sets the error flag in the written-back status and streams no byte from that buffer.
- R9: After a descriptor with bit 30 set, the next descriptor is read at `list_base` instead of 16 bytes further on.
- R10: After a halt, dropping and raising `tx_enable` restarts the walk at the current value of `list_base`.
- R11: Once `mem_req` is high, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmit enable; rising while idle starts the walk |
| list_base | input | ADDR_W | Address of the first descriptor of the list |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction completes; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available toward the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Final byte of a frame |
| tx_active | output | 1 | Engine is walking the list |

## Verification
Start-of-frame and end-of-frame can mark the same byte. A one-byte buffer whose descriptor carries both the first and last flags provokes this. The bench then expects its single captured byte to show `tx_sop` and `tx_eop` together, with the right data value.

The end of one buffer can also meet the start of the next descriptor fetch. Chained buffers and a wrapping list show that the marker flags of one descriptor never leak into the bytes of the next.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DW0,
        ST_DW1,
        ST_DW2,
        ST_FETCH,
        ST_SEND,
        ST_WBACK,
        ST_HALT
    } txd_state_e;

    localparam int CTL_LSB   = 27;
    localparam int OWN_BIT   = 31;
    localparam int WRAP_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 28;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 16;
    localparam int WORD_W    = 32;
endpackage

// File: rtl/txd_byte_pick.sv
module txd_byte_pick #(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [7:0]         byte_o
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/txd_ptr_next.sv
module txd_ptr_next #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] next_o
);
    assign next_o = wrap_i ? base_i : ptr_i + ADDR_W'(DESC_BYTES);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txdesc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [ADDR_W-1:0] list_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_active
);
    localparam int LANES   = WORD_W / 8;
    localparam int IDX_W   = $clog2(LANES);
    localparam int CTL_W   = WORD_W - CTL_LSB;
    localparam int ALIGN_W = $clog2(LANES);

    typedef struct packed {
        txd_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [CTL_W-1:0]  ctl;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] buf_a;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              err;
        logic              sent_any;
    } txd_regs_t;

    txd_regs_t q, d;

    logic [ADDR_W-1:0] ptr_nxt;
    logic [7:0]        cur_byte;
    logic              buf_bad;

    txd_ptr_next #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .ptr_i  (q.ptr),
        .base_i (list_base),
        .wrap_i (q.ctl[WRAP_BIT-CTL_LSB]),
        .next_o (ptr_nxt)
    );

    txd_byte_pick #(.LANES(LANES)) u_pick (
        .word_i (q.word),
        .sel_i  (q.idx),
        .byte_o (cur_byte)
    );

    assign buf_bad = (q.len == '0) || (mem_rdata[ALIGN_W-1:0] != '0);

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                d.ptr = list_base;
                if (tx_enable) d.st = ST_DW0;
            end
            ST_DW0: if (mem_ack) begin
                d.err = 1'b0;
                if (!mem_rdata[OWN_BIT]) begin
                    d.st = ST_HALT;
                end else begin
                    d.ctl = mem_rdata[WORD_W-1:CTL_LSB];
                    d.st  = ST_DW1;
                end
            end
            ST_DW1: if (mem_ack) begin
                d.len = mem_rdata[LEN_LSB +: LEN_W];
                d.st  = ST_DW2;
            end
            ST_DW2: if (mem_ack) begin
                d.buf_a    = mem_rdata[ADDR_W-1:0];
                d.err      = buf_bad;
                d.sent_any = 1'b0;
                d.st       = buf_bad ? ST_WBACK : ST_FETCH;
            end
            ST_FETCH: if (mem_ack) begin
                d.word  = mem_rdata;
                d.idx   = '0;
                d.buf_a = q.buf_a + ADDR_W'(LANES);
                d.st    = ST_SEND;
            end
            ST_SEND: if (tx_ready) begin
                d.sent_any = 1'b1;
                d.len      = q.len - LEN_W'(1);
                d.idx      = q.idx + IDX_W'(1);
                if (q.len == LEN_W'(1))                d.st = ST_WBACK;
                else if (q.idx == IDX_W'(LANES - 1))   d.st = ST_FETCH;
            end
            ST_WBACK: if (mem_ack) begin
                d.ptr = ptr_nxt;
                d.st  = tx_enable ? ST_DW0 : ST_IDLE;
            end
            ST_HALT: if (!tx_enable) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = q.ptr;
        case (q.st)
            ST_DW0:   mem_req = 1'b1;
            ST_DW1: begin mem_req = 1'b1; mem_addr = q.ptr + ADDR_W'(4); end
            ST_DW2: begin mem_req = 1'b1; mem_addr = q.ptr + ADDR_W'(8); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = q.buf_a; end
            ST_WBACK: begin mem_req = 1'b1; mem_we = 1'b1; end
            default:  ;
        endcase
    end

    assign mem_wdata = {1'b0, q.ctl[CTL_W-2:0], {(CTL_LSB-1){1'b0}}, q.err};
    assign tx_valid  = (q.st == ST_SEND);
    assign tx_data   = cur_byte;
    assign tx_sop    = tx_valid && q.ctl[FIRST_BIT-CTL_LSB] && !q.sent_any;
    assign tx_eop    = tx_valid && q.ctl[LAST_BIT-CTL_LSB] && (q.len == LEN_W'(1));
    assign tx_active = (q.st != ST_IDLE) && (q.st != ST_HALT);
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_sop,
    input logic              tx_eop,
    input logic              tx_active
);
    assert_hold_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_quiet_when_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (!tx_valid && !mem_req));

    assert_own_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind txdesc_dma txdesc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tx_active (tx_active)
);

// File: tb/txdesc_dma_tb.sv
module txdesc_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0;
    logic [31:0] list_base = 32'h100;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b0, tx_sop, tx_eop, tx_active;
    logic [7:0]  tx_data;

    always #5 clk = ~clk;

    txdesc_dma u_dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .list_base(list_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_active(tx_active)
    );

    logic [31:0] mem [0:1023];
    logic [7:0]  cap_d [0:63];
    logic        cap_s [0:63];
    logic        cap_e [0:63];
    int          ncap = 0, lat = 0, waitc = 0, viol = 0, n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0]  rdy_pat = 8'hFF;
    logic [2:0]  phase = '0;
    logic [31:0] seen_addr = '0;

    // fields: len[27:12] mis[11:10] first[9] last[8] ready pattern[7:0]
    localparam logic [27:0] VEC [8] = '{
        {16'd5,  2'd0, 1'b1, 1'b1, 8'hFF},
        {16'd1,  2'd0, 1'b1, 1'b1, 8'hFF},
        {16'd8,  2'd0, 1'b1, 1'b0, 8'hA5},
        {16'd3,  2'd0, 1'b0, 1'b1, 8'h33},
        {16'd0,  2'd0, 1'b1, 1'b1, 8'hFF},
        {16'd4,  2'd2, 1'b1, 1'b1, 8'hFF},
        {16'd13, 2'd0, 1'b1, 1'b1, 8'h96},
        {16'd2,  2'd0, 1'b0, 1'b0, 8'h0F}
    };

    function automatic logic [7:0] pb(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++)
            mem[i] = {pb(4*i+3), pb(4*i+2), pb(4*i+1), pb(4*i)};
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, input logic [15:0] len, input logic [31:0] ba);
        mem[a>>2]     = w0;
        mem[(a>>2)+1] = {len, 16'hBEEF};
        mem[(a>>2)+2] = ba;
        mem[(a>>2)+3] = 32'hDEAD0000;
    endtask

    function automatic logic [31:0] ctl_word(input bit own, input bit wrap, input bit f, input bit l);
        return {own, wrap, f, l, 1'b1, 27'd0};
    endfunction

    task automatic run_list();
        int t;
        ncap = 0;
        tx_enable = 1'b1;
        t = 0;
        while (!tx_active && t < 50) begin @(negedge clk); t++; end
        t = 0;
        while (tx_active && t < 5000) begin @(negedge clk); t++; end
        tx_enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // frame check over captured bytes [off, off+len)
    task automatic chk_bytes(input int off, input int len, input int ba, input string req);
        int errs = 0;
        for (int i = 0; i < len; i++)
            if (cap_d[off+i] !== pb(ba+i)) errs++;
        chk(errs == 0, req, errs, 0);
    endtask

    // memory and stream responder
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = rdy_pat[phase];
            phase = phase + 3'd1;
            if (tx_valid && tx_ready && ncap < 64) begin
                cap_d[ncap] = tx_data; cap_s[ncap] = tx_sop; cap_e[ncap] = tx_eop;
                ncap++;
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
                waitc = 0;
            end else if (mem_req) begin
                if (waitc == 0) seen_addr = mem_addr;
                else if (mem_addr !== seen_addr) viol++;
                if (waitc >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem[mem_addr[11:2]];
                    if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                end else begin
                    waitc++;
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        chk(!tx_active && !tx_valid && !mem_req, "R1", {tx_active, tx_valid, mem_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!tx_active && !tx_valid && !mem_req, "R1", {tx_active, tx_valid, mem_req}, 0);

        // table walk: one descriptor per vector, then an unowned one
        for (int v = 0; v < 8; v++) begin
            logic [15:0] len;
            logic [1:0]  mis;
            logic        f, l, err;
            int          nexp;
            len = VEC[v][27:12]; mis = VEC[v][11:10]; f = VEC[v][9]; l = VEC[v][8];
            rdy_pat = VEC[v][7:0];
            err = (len == 0) || (mis != 0);
            nexp = err ? 0 : int'(len);
            init_mem();
            put_desc(32'h100, ctl_word(1, 0, f, l), len, 32'h800 + mis);
            mem[32'h110>>2] = 32'h0;
            run_list();
            chk(ncap == nexp, err ? "R8" : "R4", ncap, nexp);
            if (nexp > 0) begin
                chk_bytes(0, nexp, 32'h800, "R4");
                chk(cap_s[0] == f && cap_e[nexp-1] == l, "R5", {cap_s[0], cap_e[nexp-1]}, {f, l});
                if (nexp > 1)
                    chk(!cap_e[0] && !cap_s[nexp-1], "R5", {cap_e[0], cap_s[nexp-1]}, 0);
            end
            chk(mem[32'h100>>2] == {1'b0, 4'b0000 | {1'b0, f, l, 1'b1}, 26'd0, err}, "R7",
                mem[32'h100>>2], {1'b0, 1'b0, f, l, 1'b1, 26'd0, err});
            chk(mem[32'h110>>2] == 32'h0 && !tx_active, "R3", mem[32'h110>>2], 0);
        end

        // chained buffers forming one frame, with slow memory
        rdy_pat = 8'hFF; lat = 3; viol = 0;
        init_mem();
        put_desc(32'h100, ctl_word(1, 0, 1, 0), 16'd6, 32'h800);
        put_desc(32'h110, ctl_word(1, 0, 0, 1), 16'd5, 32'h900);
        mem[32'h120>>2] = 32'h0;
        run_list();
        chk(ncap == 11, "R2", ncap, 11);
        chk_bytes(0, 6, 32'h800, "R2");
        chk_bytes(6, 5, 32'h900, "R4");
        begin
            int sops = 0, eops = 0;
            for (int i = 0; i < ncap; i++) begin sops += int'(cap_s[i]); eops += int'(cap_e[i]); end
            chk(cap_s[0] && cap_e[10] && sops == 1 && eops == 1, "R5", {sops[7:0], eops[7:0]}, 32'h0101);
        end
        chk(mem[32'h110>>2][31] == 1'b0, "R2", mem[32'h110>>2], {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 27'd0});
        chk(viol == 0, "R11", viol, 0);
        lat = 0;

        // wrap flag returns to the list start, which is now released
        init_mem();
        put_desc(32'h100, ctl_word(1, 1, 1, 1), 16'd2, 32'h800);
        put_desc(32'h110, ctl_word(1, 0, 1, 1), 16'd2, 32'h900);
        run_list();
        chk(ncap == 2, "R9", ncap, 2);
        chk(mem[32'h110>>2] == ctl_word(1, 0, 1, 1), "R9", mem[32'h110>>2], ctl_word(1, 0, 1, 1));
        chk(mem[32'h100>>2] == {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 27'd0}, "R7",
            mem[32'h100>>2], {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 27'd0});

        // restart after halt from a new list start
        init_mem();
        list_base = 32'h200;
        put_desc(32'h200, ctl_word(1, 0, 1, 1), 16'd3, 32'hA00);
        put_desc(32'h100, ctl_word(1, 0, 1, 1), 16'd3, 32'h800);
        mem[32'h210>>2] = 32'h0;
        run_list();
        chk(ncap == 3, "R10", ncap, 3);
        chk_bytes(0, 3, 32'hA00, "R10");
        chk(mem[32'h100>>2][31] == 1'b1 && mem[32'h200>>2][31] == 1'b0, "R10",
            {mem[32'h100>>2][31], mem[32'h200>>2][31]}, 2'b10);

        // unowned first descriptor: nothing streamed, nothing written
        init_mem();
        mem[32'h200>>2] = 32'h3800_0000;
        run_list();
        chk(ncap == 0 && mem[32'h200>>2] == 32'h3800_0000, "R3", mem[32'h200>>2], 32'h3800_0000);
        chk(!tx_active && !tx_valid, "R3", {tx_active, tx_valid}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule